// File: doc/BRIEF.md
# SPI Data FIFO Pair with Level Events

This block holds the two data queues that sit between a processor's data port and a serial shift engine. The transmit queue is filled by the processor and drained by the engine. The receive queue is filled by the engine and drained by the processor. Each queue stores 256 bytes. Software picks the entry size of each queue at run time: 8, 16 or 32 bits. A queue of 32-bit entries therefore holds 64 entries, and a queue of bytes holds 256.

Each queue has its own control word, which sets the entry size and an 8-bit threshold. It also has an operation word that can empty the queue and start or stop it, and a status word that gives the fill level, full and empty. Fill changes raise events: receive overflow, transmit underflow, receive full, transmit empty, and a threshold crossing on each side. The engine supplies three more events: receive done, transmit done and frame end. All events collect in one interrupt status register that software clears by writing ones. A second register of enable bits decides which status bits drive the interrupt line.

Top module: `spf_fifo_pair`

## Requirements
- R1: After reset both status words read 10'h200 (empty set, full clear, level 0). The interrupt status and enable registers read 0, `irq` is low and both pop data outputs are 0.
- R2: Control word bits [1:0] select the entry size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. Entries come out in push order. Only the low entry-size bits of a pushed word are kept, and the upper bits of pop data read zero.
- R3: A queue is full when it holds 256 bytes: 256, 128 or 64 entries. The status word carries the entry count modulo 256 in bits [7:0], full in bit 8 and empty in bit 9.
- R4: A push while the queue is full is dropped and the stored entries are unchanged. On the receive queue this sets interrupt status bit 2.
- R5: A pop while the queue is empty returns zero. On the transmit queue this sets interrupt status bit 3. On the receive queue it sets no status bit.
- R6: Operation word bit 0 empties the queue, and bit 1 set runs it. While the queue is not running, push and pop leave it unchanged. Writing 0 stops the queue and keeps its contents.
- R7: Control word bits [9:2] hold a threshold counted in entries. Interrupt status bit 8 is set when the receive level rises to at least the threshold. Bit 9 is set when the transmit level falls to at most the threshold. Each bit is set on the change, one cycle after the level changes.
- R8: Interrupt status bit 6 is set when the receive queue becomes full. Bit 7 is set when the transmit queue becomes empty. Each bit is set one cycle after the change.
- R9: One-cycle pulses on the engine inputs set interrupt status bit 0 (receive done), bit 1 (transmit done) and bit 10 (frame end).
- R10: Writing the status register clears the bits written as one and leaves the bits written as zero. If a bit is set and cleared in the same cycle, the set wins.
- R11: `irq` is high exactly when some status bit has its enable bit set. Enable bits 4 and 5 are reserved and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_ctl_we | input | 1 | Write strobe for the transmit control word |
| tx_ctl_wdata | input | 10 | Transmit control: [9:2] threshold, [1:0] entry size |
| tx_op_we | input | 1 | Write strobe for the transmit operation word |
| tx_op_wdata | input | 2 | Transmit operation: bit 0 empty, bit 1 run |
| tx_push | input | 1 | Processor pushes an entry into the transmit queue |
| tx_push_data | input | 32 | Transmit push data |
| tx_pop | input | 1 | Engine takes the head of the transmit queue |
| tx_pop_data | output | 32 | Transmit head entry, zero when empty |
| tx_status | output | 10 | Transmit status: [9] empty, [8] full, [7:0] level |
| rx_ctl_we | input | 1 | Write strobe for the receive control word |
| rx_ctl_wdata | input | 10 | Receive control: [9:2] threshold, [1:0] entry size |
| rx_op_we | input | 1 | Write strobe for the receive operation word |
| rx_op_wdata | input | 2 | Receive operation: bit 0 empty, bit 1 run |
| rx_push | input | 1 | Engine pushes a received entry |
| rx_push_data | input | 32 | Receive push data |
| rx_pop | input | 1 | Processor takes the head of the receive queue |
| rx_pop_data | output | 32 | Receive head entry, zero when empty |
| rx_status | output | 10 | Receive status: [9] empty, [8] full, [7:0] level |
| eng_rx_done | input | 1 | Engine pulse: receive done |
| eng_tx_done | input | 1 | Engine pulse: transmit done |
| eng_frame_end | input | 1 | Engine pulse: frame end |
| int_en_we | input | 1 | Write strobe for the interrupt enable register |
| int_en_wdata | input | 11 | New interrupt enable bits |
| int_clr_we | input | 1 | Write strobe for clearing interrupt status |
| int_clr_wdata | input | 11 | Ones clear the matching status bits |
| int_status | output | 11 | Interrupt status register |
| int_enable | output | 11 | Interrupt enable register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the edge of the full 256-byte capacity at each entry size. In byte mode the level field wraps to zero exactly when the full flag rises, and an extra push must disappear without disturbing any stored entry. The stimulus fills each queue entry by entry to the last slot at 8-bit, 16-bit and 32-bit size. It then pushes one more word and drains the whole queue in order, which shows that the extra word was never stored. The event bits that fire on a change are checked with status cleared first and at the cycle after the level change, because a level that stays true must not set a bit again.

// File: rtl/spf_pkg.sv
package spf_pkg;

    // Interrupt status layout; positions are decoded by software.
    localparam int unsigned IST_W        = 11;
    localparam int unsigned IST_RX_DONE  = 0;
    localparam int unsigned IST_TX_DONE  = 1;
    localparam int unsigned IST_RX_OVF   = 2;
    localparam int unsigned IST_TX_UDF   = 3;
    localparam int unsigned IST_RX_FULL  = 6;
    localparam int unsigned IST_TX_EMPTY = 7;
    localparam int unsigned IST_RX_THR   = 8;
    localparam int unsigned IST_TX_THR   = 9;
    localparam int unsigned IST_FRM_END  = 10;
    localparam logic [IST_W-1:0] IST_VALID = 11'h7CF;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2,
        WID_RSV = 2'd3
    } wid_e;

    typedef struct packed {
        logic [7:0] thresh;
        logic [1:0] width;
    } fifo_ctl_t;

    typedef struct packed {
        logic       empty;
        logic       full;
        logic [7:0] level;
    } fifo_stat_t;

    // log2 of bytes per entry; the reserved code behaves as 32-bit
    function automatic logic [1:0] wid_shift(input logic [1:0] w);
        case (wid_e'(w))
            WID_8:   return 2'd0;
            WID_16:  return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/spf_fifo.sv
module spf_fifo
    import spf_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned DW    = 32,
    parameter bit          DRAIN = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_we,
    input  logic [9:0]    ctl_wdata,
    input  logic          op_we,
    input  logic [1:0]    op_wdata,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output fifo_stat_t    stat,
    output logic          is_full,
    output logic          is_empty,
    output logic          thr_hit,
    output logic          ovf,
    output logic          udf
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = PW + 1;
    localparam int unsigned NL = DW / 8;

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] bcnt;
    logic          run;
    fifo_ctl_t     ctl_q;

    logic [1:0]    shift;
    logic [CW-1:0] bpe;
    logic [CW:0]   room_sum;
    logic [CW-1:0] lvl;
    logic          op_clr, do_push, do_pop;
    logic [DW-1:0] head;

    assign shift    = wid_shift(ctl_q.width);
    assign bpe      = CW'(1) << shift;
    assign room_sum = {1'b0, bcnt} + {1'b0, bpe};
    assign is_full  = room_sum > (CW+1)'(DEPTH);
    assign is_empty = bcnt < bpe;
    assign lvl      = bcnt >> shift;

    assign op_clr  = op_we && op_wdata[0];
    assign do_push = push && run && !is_full && !op_clr;
    assign do_pop  = pop && run && !is_empty && !op_clr;
    assign ovf     = push && run && is_full;
    assign udf     = pop && run && is_empty;

    // Control and run state
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            run   <= 1'b0;
        end else begin
            if (ctl_we) ctl_q <= fifo_ctl_t'(ctl_wdata);
            if (op_we)  run   <= op_wdata[1];
        end
    end

    // Pointers and byte count
    always_ff @(posedge clk) begin
        if (rst || op_clr) begin
            wptr <= '0;
            rptr <= '0;
            bcnt <= '0;
        end else begin
            if (do_push) wptr <= wptr + PW'(bpe);
            if (do_pop)  rptr <= rptr + PW'(bpe);
            case ({do_push, do_pop})
                2'b10:   bcnt <= bcnt + bpe;
                2'b01:   bcnt <= bcnt - bpe;
                default: bcnt <= bcnt;
            endcase
        end
    end

    // Byte-lane storage
    always_ff @(posedge clk) begin
        if (do_push) begin
            for (int k = 0; k < NL; k++) begin
                if (CW'(k) < bpe) mem[wptr + PW'(k)] <= push_data[8*k +: 8];
            end
        end
    end

    always_comb begin
        head = '0;
        for (int k = 0; k < NL; k++) begin
            if (CW'(k) < bpe) head[8*k +: 8] = mem[rptr + PW'(k)];
        end
    end

    assign pop_data = is_empty ? '0 : head;

    assign stat.empty = is_empty;
    assign stat.full  = is_full;
    assign stat.level = lvl[7:0];

    // Threshold direction depends on which side drains the queue
    generate
        if (DRAIN) begin : g_drain_thr
            assign thr_hit = lvl <= CW'(ctl_q.thresh);
        end else begin : g_fill_thr
            assign thr_hit = lvl >= CW'(ctl_q.thresh);
        end
    endgenerate

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        bcnt <= CW'(DEPTH));

    assert_drop_keeps_count_R4: assert property (@(posedge clk) disable iff (rst)
        (push && run && is_full && !pop && !op_we) |=> $stable(bcnt));

    assert_underflow_zero_R5: assert property (@(posedge clk) disable iff (rst)
        udf |-> (pop_data == '0));

    assert_opreset_empties_R6: assert property (@(posedge clk) disable iff (rst)
        op_clr |=> (bcnt == '0));

    assert_stopped_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (!run && !op_we) |=> $stable(bcnt));

endmodule

// File: rtl/spf_rise.sv
module spf_rise #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev;

    // Reset to all ones so conditions already true at reset raise nothing
    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= cond;
    end

    assign rise = cond & ~prev;

endmodule

// File: rtl/spf_irq.sv
module spf_irq
    import spf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IST_W-1:0] set_vec,
    input  logic             clr_we,
    input  logic [IST_W-1:0] clr_data,
    input  logic             en_we,
    input  logic [IST_W-1:0] en_data,
    output logic [IST_W-1:0] stat_q,
    output logic [IST_W-1:0] en_q,
    output logic             irq
);
    logic [IST_W-1:0] clr_mask;

    assign clr_mask = clr_we ? clr_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= ((stat_q & ~clr_mask) | set_vec) & IST_VALID;
            if (en_we) en_q <= en_data & IST_VALID;
        end
    end

    assign irq = |(stat_q & en_q);

    generate
        for (genvar i = 0; i < IST_W; i++) begin : g_w1c_chk
            assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
                (clr_we && clr_data[i] && !set_vec[i]) |=> !stat_q[i]);
            assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
                (set_vec[i] && IST_VALID[i]) |=> stat_q[i]);
        end
    endgenerate

endmodule

// File: rtl/spf_fifo_pair.sv
module spf_fifo_pair
    import spf_pkg::*;
#(
    parameter int unsigned DEPTH_BYTES = 256,
    parameter int unsigned DW          = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_ctl_we,
    input  logic [9:0]    tx_ctl_wdata,
    input  logic          tx_op_we,
    input  logic [1:0]    tx_op_wdata,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_push_data,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_pop_data,
    output logic [9:0]    tx_status,
    input  logic          rx_ctl_we,
    input  logic [9:0]    rx_ctl_wdata,
    input  logic          rx_op_we,
    input  logic [1:0]    rx_op_wdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_push_data,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_pop_data,
    output logic [9:0]    rx_status,
    input  logic          eng_rx_done,
    input  logic          eng_tx_done,
    input  logic          eng_frame_end,
    input  logic          int_en_we,
    input  logic [10:0]   int_en_wdata,
    input  logic          int_clr_we,
    input  logic [10:0]   int_clr_wdata,
    output logic [10:0]   int_status,
    output logic [10:0]   int_enable,
    output logic          irq
);
    localparam int unsigned NCOND = 4;

    fifo_stat_t tx_st, rx_st;
    logic tx_full, tx_empty, tx_thr, tx_ovf, tx_udf;
    logic rx_full, rx_empty, rx_thr, rx_ovf, rx_udf;
    logic [NCOND-1:0] cond, rise;
    logic [IST_W-1:0] set_vec;

    spf_fifo #(.DEPTH(DEPTH_BYTES), .DW(DW), .DRAIN(1'b1)) u_tx (
        .clk(clk), .rst(rst),
        .ctl_we(tx_ctl_we), .ctl_wdata(tx_ctl_wdata),
        .op_we(tx_op_we), .op_wdata(tx_op_wdata),
        .push(tx_push), .push_data(tx_push_data),
        .pop(tx_pop), .pop_data(tx_pop_data),
        .stat(tx_st), .is_full(tx_full), .is_empty(tx_empty),
        .thr_hit(tx_thr), .ovf(tx_ovf), .udf(tx_udf)
    );

    spf_fifo #(.DEPTH(DEPTH_BYTES), .DW(DW), .DRAIN(1'b0)) u_rx (
        .clk(clk), .rst(rst),
        .ctl_we(rx_ctl_we), .ctl_wdata(rx_ctl_wdata),
        .op_we(rx_op_we), .op_wdata(rx_op_wdata),
        .push(rx_push), .push_data(rx_push_data),
        .pop(rx_pop), .pop_data(rx_pop_data),
        .stat(rx_st), .is_full(rx_full), .is_empty(rx_empty),
        .thr_hit(rx_thr), .ovf(rx_ovf), .udf(rx_udf)
    );

    assign tx_status = tx_st;
    assign rx_status = rx_st;

    // Conditions turned into one-shot events: full, empty, thresholds
    assign cond = {tx_thr, rx_thr, tx_empty, rx_full};

    spf_rise #(.N(NCOND)) u_rise (
        .clk(clk), .rst(rst), .cond(cond), .rise(rise)
    );

    always_comb begin
        set_vec               = '0;
        set_vec[IST_RX_DONE]  = eng_rx_done;
        set_vec[IST_TX_DONE]  = eng_tx_done;
        set_vec[IST_RX_OVF]   = rx_ovf;
        set_vec[IST_TX_UDF]   = tx_udf;
        set_vec[IST_RX_FULL]  = rise[0];
        set_vec[IST_TX_EMPTY] = rise[1];
        set_vec[IST_RX_THR]   = rise[2];
        set_vec[IST_TX_THR]   = rise[3];
        set_vec[IST_FRM_END]  = eng_frame_end;
    end

    spf_irq u_irq (
        .clk(clk), .rst(rst), .set_vec(set_vec),
        .clr_we(int_clr_we), .clr_data(int_clr_wdata),
        .en_we(int_en_we), .en_data(int_en_wdata),
        .stat_q(int_status), .en_q(int_enable), .irq(irq)
    );

    // Side-specific flags with no status bit of their own
    logic unused_ok;
    assign unused_ok = ^{tx_ovf, tx_full, rx_udf, rx_empty};

    assert_rx_ovf_sets_R4: assert property (@(posedge clk) disable iff (rst)
        rx_ovf |=> int_status[IST_RX_OVF]);

    assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (int_enable != '0));

endmodule

// File: tb/tb_spf_fifo_pair.sv
module tb_spf_fifo_pair;
    localparam int CLK_PER = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic        tx_ctl_we = 0, tx_op_we = 0, tx_push = 0, tx_pop = 0;
    logic [9:0]  tx_ctl_wdata = '0;
    logic [1:0]  tx_op_wdata = '0;
    logic [31:0] tx_push_data = '0, tx_pop_data;
    logic [9:0]  tx_status;
    logic        rx_ctl_we = 0, rx_op_we = 0, rx_push = 0, rx_pop = 0;
    logic [9:0]  rx_ctl_wdata = '0;
    logic [1:0]  rx_op_wdata = '0;
    logic [31:0] rx_push_data = '0, rx_pop_data;
    logic [9:0]  rx_status;
    logic        eng_rx_done = 0, eng_tx_done = 0, eng_frame_end = 0;
    logic        int_en_we = 0, int_clr_we = 0;
    logic [10:0] int_en_wdata = '0, int_clr_wdata = '0;
    logic [10:0] int_status, int_enable;
    logic        irq;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_PER/2) clk = ~clk;

    spf_fifo_pair dut (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tx_cfg(input logic [9:0] c, input logic [1:0] op);
        tx_ctl_we = 1; tx_ctl_wdata = c; tx_op_we = 1; tx_op_wdata = op;
        tick();
        tx_ctl_we = 0; tx_op_we = 0;
    endtask

    task automatic rx_cfg(input logic [9:0] c, input logic [1:0] op);
        rx_ctl_we = 1; rx_ctl_wdata = c; rx_op_we = 1; rx_op_wdata = op;
        tick();
        rx_ctl_we = 0; rx_op_we = 0;
    endtask

    task automatic tx_opw(input logic [1:0] op);
        tx_op_we = 1; tx_op_wdata = op; tick(); tx_op_we = 0;
    endtask

    task automatic tx_put(input logic [31:0] d);
        tx_push = 1; tx_push_data = d; tick(); tx_push = 0;
    endtask

    task automatic rx_put(input logic [31:0] d);
        rx_push = 1; rx_push_data = d; tick(); rx_push = 0;
    endtask

    task automatic tx_take();
        tx_pop = 1; tick(); tx_pop = 0;
    endtask

    task automatic rx_take();
        rx_pop = 1; tick(); rx_pop = 0;
    endtask

    task automatic clr_st(input logic [10:0] m);
        int_clr_we = 1; int_clr_wdata = m; tick(); int_clr_we = 0;
    endtask

    task automatic t_reset();
        chk("R1 tx status", 32'(tx_status), 32'h200);
        chk("R1 rx status", 32'(rx_status), 32'h200);
        chk("R1 int status", 32'(int_status), 0);
        chk("R1 int enable", 32'(int_enable), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 pop data", tx_pop_data | rx_pop_data, 0);
    endtask

    task automatic t_byte_fill();
        int bad = 0;
        tx_cfg(10'h000, 2'b11);
        clr_st(11'h7FF);
        for (int i = 0; i < 256; i++) tx_put(32'(i) | 32'hFFFF_FF00);
        chk("R3 byte full level wraps", 32'(tx_status), 32'h100);
        tx_put(32'hEE);
        chk("R4 tx drop keeps full", 32'(tx_status), 32'h100);
        chk("R4 tx drop no rx ovf bit", 32'(int_status[2]), 0);
        for (int i = 0; i < 256; i++) begin
            if (tx_pop_data !== 32'(i)) bad++;
            tx_take();
        end
        chk("R2 byte order and upper zero", 32'(bad), 0);
        chk("R3 tx empty after drain", 32'(tx_status), 32'h200);
        tick();
        chk("R8 tx empty event", 32'(int_status[7]), 1);
    endtask

    task automatic t_rx_word();
        int bad = 0;
        rx_cfg(10'h002, 2'b11);
        clr_st(11'h7FF);
        for (int i = 0; i < 64; i++) rx_put(32'hA500_0000 | 32'(i));
        chk("R3 word full at 64", 32'(rx_status), 32'h140);
        tick();
        chk("R8 rx full event", 32'(int_status[6]), 1);
        chk("R4 no ovf before extra push", 32'(int_status[2]), 0);
        rx_put(32'hDEAD_BEEF);
        chk("R4 rx overflow bit", 32'(int_status[2]), 1);
        chk("R4 rx level unchanged", 32'(rx_status), 32'h140);
        for (int i = 0; i < 64; i++) begin
            if (rx_pop_data !== (32'hA500_0000 | 32'(i))) bad++;
            rx_take();
        end
        chk("R2 word order, dropped word absent", 32'(bad), 0);
        chk("R5 empty rx pop data", rx_pop_data, 0);
    endtask

    task automatic t_half();
        tx_cfg(10'h001, 2'b11);
        tx_put(32'hFFFF_1234);
        tx_put(32'h0000_ABCD);
        chk("R3 half level 2", 32'(tx_status), 32'h002);
        chk("R2 half first", tx_pop_data, 32'h0000_1234);
        tx_take();
        chk("R2 half second", tx_pop_data, 32'h0000_ABCD);
        tx_take();
        for (int i = 0; i < 128; i++) tx_put(32'(i));
        chk("R3 half full at 128", 32'(tx_status), 32'h180);
        tx_opw(2'b01);
        chk("R6 op bit0 empties", 32'(tx_status), 32'h200);
    endtask

    task automatic t_underflow();
        tx_cfg(10'h000, 2'b11);
        rx_cfg(10'h000, 2'b11);
        tick();
        clr_st(11'h7FF);
        chk("R5 empty tx pop data", tx_pop_data, 0);
        tx_take();
        chk("R5 tx underflow bit", 32'(int_status[3]), 1);
        clr_st(11'h7FF);
        rx_take();
        chk("R5 rx empty pop sets nothing", 32'(int_status), 0);
    endtask

    task automatic t_stop();
        tx_cfg(10'h000, 2'b11);
        tx_put(32'h1); tx_put(32'h2); tx_put(32'h3);
        tx_opw(2'b00);
        tx_put(32'h9);
        chk("R6 push ignored when stopped", 32'(tx_status), 32'h003);
        tx_take();
        chk("R6 pop ignored when stopped", 32'(tx_status), 32'h003);
        tx_opw(2'b10);
        chk("R6 contents kept over stop", tx_pop_data, 32'h1);
        tx_opw(2'b01);
        chk("R6 reset empties", 32'(tx_status), 32'h200);
    endtask

    task automatic t_thresh();
        rx_cfg(10'h00C, 2'b11);
        tick();
        clr_st(11'h7FF);
        rx_put(32'h1); rx_put(32'h2);
        tick();
        chk("R7 rx below threshold", 32'(int_status[8]), 0);
        rx_put(32'h3);
        chk("R7 rx event one cycle late", 32'(int_status[8]), 0);
        tick();
        chk("R7 rx threshold reached", 32'(int_status[8]), 1);
        tx_cfg(10'h004, 2'b11);
        tx_put(32'h1); tx_put(32'h2); tx_put(32'h3);
        tick();
        clr_st(11'h7FF);
        tx_take();
        tick();
        chk("R7 tx above threshold", 32'(int_status[9]), 0);
        tx_take();
        tick();
        chk("R7 tx threshold reached", 32'(int_status[9]), 1);
        clr_st(11'h7FF);
        tick();
        chk("R7 no refire while held", 32'(int_status[9]), 0);
        tx_opw(2'b01);
        rx_cfg(10'h000, 2'b01);
        tick();
        clr_st(11'h7FF);
    endtask

    task automatic t_engine();
        eng_rx_done = 1; tick(); eng_rx_done = 0;
        chk("R9 rx done bit0", 32'(int_status), 32'h001);
        eng_tx_done = 1; tick(); eng_tx_done = 0;
        eng_frame_end = 1; tick(); eng_frame_end = 0;
        chk("R9 tx done and frame end", 32'(int_status), 32'h403);
    endtask

    task automatic t_w1c();
        clr_st(11'h001);
        chk("R10 single clear", 32'(int_status), 32'h402);
        eng_frame_end = 1; int_clr_we = 1; int_clr_wdata = 11'h400;
        tick();
        eng_frame_end = 0; int_clr_we = 0;
        chk("R10 set wins", 32'(int_status), 32'h402);
        clr_st(11'h7FF);
        chk("R10 clear all", 32'(int_status), 0);
    endtask

    task automatic t_irq();
        int_en_we = 1; int_en_wdata = 11'h002; tick(); int_en_we = 0;
        chk("R11 enable readback", 32'(int_enable), 32'h002);
        eng_rx_done = 1; tick(); eng_rx_done = 0;
        chk("R11 masked source quiet", 32'(irq), 0);
        eng_tx_done = 1; tick(); eng_tx_done = 0;
        chk("R11 enabled source raises", 32'(irq), 1);
        clr_st(11'h002);
        chk("R11 clear drops irq", 32'(irq), 0);
        int_en_we = 1; int_en_wdata = 11'h7FF; tick(); int_en_we = 0;
        chk("R11 reserved enable bits", 32'(int_enable), 32'h7CF);
        chk("R11 irq from bit0", 32'(irq), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        tick();
        t_reset();
        t_byte_fill();
        t_rx_word();
        t_half();
        t_underflow();
        t_stop();
        t_thresh();
        t_engine();
        t_w1c();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(CLK_PER * 100000);
        nchk++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule